// File: doc/BRIEF.md
# Serial Register Port with Burst Read

This block is the host-facing serial slave of a motion-sensing device. A host drives a four-wire serial link (clock, data in, data out, active-low select). The block oversamples the link with its own system clock. It decodes two-byte register commands and turns each one into a single-cycle strobe on a simple register-file interface, which the device's internal logic serves. Read data goes back to the host on the data-out line, with an output-enable that is asserted only while the select line is low.

A read of one special address starts a burst. After the address byte, the block fetches seven motion and frame-statistics bytes from the register file and streams them to the host with no further address bytes. The burst then holds the port until the select line goes high again.

Two values are answered inside the block: a link-check identification byte and its bitwise inverse. A write of a fixed key to a fixed address raises a one-cycle reset request toward the rest of the device.

Top module: `spi_regport`

## Requirements
- R1: The first byte of a command is a direction bit followed by a 7-bit address, most significant bit first, sampled on rising serial-clock edges. The second byte is the data byte. Direction 1 is a write. The completed write appears as a one-cycle `reg_wr` with the address on `reg_addr` and the data on `reg_wdata`.
- R2: For a read (direction 0), the data byte is driven on `miso_o` most significant bit first. Each bit changes only after a falling serial-clock edge, beginning with the falling edge that follows the eighth rising edge, and holds until the next falling edge.
- R3: While the select line is high, `miso_oe` is low and no `reg_wr`, `reg_rd` or `reg_reset_req` is issued.
- R4: Raising the select line part-way through a command discards it without any strobe. The next command framed by the select line decodes from its first bit.
- R5: A read of address 0x42 starts a burst. Right after the address byte, the block issues seven `reg_rd` strobes at addresses 0x02 through 0x08, in ascending order. The host then receives those seven bytes, in that order, back to back.
- R6: Once a burst has started, no further strobe is issued until the select line has been high. Bits clocked beyond the seventh burst byte read as 0.
- R7: A write of 0x5A to address 0x3A produces a one-cycle `reg_reset_req` and no `reg_wr`. Any other data byte written to 0x3A produces neither.
- R8: A read of address 0x00 returns 0x0D and a read of address 0x3F returns 0xF2. Neither read issues `reg_rd`.
- R9: A read of an address from 0x01 to 0x11 issues one `reg_rd` and returns `reg_rdata`. A read of any other address, apart from those in R5 and R8, returns 0x00 with no `reg_rd`.
- R10: Only writes to 0x02, 0x0B and 0x11 are forwarded as `reg_wr`. A write to any other address is dropped.
- R11: Commands may follow one another inside one low period of the select line, and each is decoded in turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from host, idles high |
| mosi | input | 1 | Serial data from host |
| cs_n | input | 1 | Active-low select from host |
| miso_o | output | 1 | Serial data to host |
| miso_oe | output | 1 | Output enable for the data-out pad |
| reg_addr | output | 7 | Register-file address |
| reg_wdata | output | 8 | Register-file write data |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle read strobe; `reg_rdata` is taken in the same cycle |
| reg_rdata | input | 8 | Register-file read data |
| reg_reset_req | output | 1 | One-cycle device reset request |

## Verification
The bench targets select-line aborts part-way through an address byte. A design that kept its bit count across the abort would misframe the next command and write the wrong register. Bursts are clocked past their seventh byte and then followed by a whole write inside the same select period. A port that did not lock would issue an extra strobe, and one that did not drain cleanly would return stale bytes. Identification, unmapped and read-only addresses, the reset key against a wrong key, and back-to-back commands without a select toggle are also covered. A bad address decoder would show up in these as a wrong returned byte or as a stray or missing strobe.

// File: rtl/spi_regport.sv
`timescale 1ns/1ps
module spi_regport #(
  parameter logic [7:0] ID_CODE   = 8'h0D,
  parameter logic [6:0] BURST_ADR = 7'h42,
  parameter logic [6:0] RST_ADR   = 7'h3A,
  parameter logic [7:0] RST_KEY   = 8'h5A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       mosi,
  input  logic       cs_n,
  output logic       miso_o,
  output logic       miso_oe,
  output logic [6:0] reg_addr,
  output logic [7:0] reg_wdata,
  output logic       reg_wr,
  output logic       reg_rd,
  input  logic [7:0] reg_rdata,
  output logic       reg_reset_req
);
  localparam int BLEN = 7;
  localparam int OUTW = BLEN * 8;
  localparam logic [6:0] INV_ADR = 7'h3F;
  localparam logic [6:0] BURST_BASE = 7'h02;

  logic [2:0] sclk_s;
  logic [1:0] mosi_s, cs_s;
  logic       active, s_rise, s_fall;

  logic [3:0] bitcnt;
  logic [6:0] sh_in;
  logic [6:0] addr_q;
  logic       dir_q, rd_pend, burst, bcap;
  logic [2:0] bctr;
  logic [OUTW-1:0] out_sr;
  logic       miso_q;

  logic [7:0] cur_byte;
  logic       readable, writable;
  logic [7:0] rd_val;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_s <= 3'b111;
      mosi_s <= 2'b00;
      cs_s   <= 2'b11;
    end else begin
      sclk_s <= {sclk_s[1:0], sclk};
      mosi_s <= {mosi_s[0], mosi};
      cs_s   <= {cs_s[0], cs_n};
    end

  assign active   = ~cs_s[1];
  assign s_rise   = sclk_s[1] & ~sclk_s[2];
  assign s_fall   = ~sclk_s[1] & sclk_s[2];
  assign cur_byte = {sh_in, mosi_s[1]};

  assign readable = (addr_q >= 7'h01) && (addr_q <= 7'h11);
  assign writable = (addr_q == 7'h02) || (addr_q == 7'h0B) || (addr_q == 7'h11);
  assign rd_val   = (addr_q == 7'h00)   ? ID_CODE :
                    (addr_q == INV_ADR) ? ~ID_CODE :
                    readable            ? reg_rdata : 8'h00;

  assign reg_addr = bcap ? BURST_BASE + {4'b0, bctr} : addr_q;
  assign reg_rd   = bcap | (rd_pend & readable);
  assign miso_o   = miso_q;
  assign miso_oe  = active;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      bitcnt <= '0; sh_in <= '0; addr_q <= '0; dir_q <= 1'b0;
      rd_pend <= 1'b0; burst <= 1'b0; bcap <= 1'b0; bctr <= '0;
      out_sr <= '0; miso_q <= 1'b0;
      reg_wr <= 1'b0; reg_wdata <= '0; reg_reset_req <= 1'b0;
    end else if (!active) begin
      bitcnt <= '0; rd_pend <= 1'b0; burst <= 1'b0; bcap <= 1'b0;
      reg_wr <= 1'b0; reg_reset_req <= 1'b0;
    end else begin
      reg_wr <= 1'b0;
      reg_reset_req <= 1'b0;
      rd_pend <= 1'b0;
      if (rd_pend) out_sr <= {rd_val, {(OUTW-8){1'b0}}};
      if (bcap) begin
        out_sr <= {out_sr[OUTW-9:0], reg_rdata};
        bctr   <= bctr + 3'd1;
        if (bctr == 3'(BLEN-1)) bcap <= 1'b0;
      end
      if (s_rise && !burst) begin
        sh_in  <= cur_byte[6:0];
        bitcnt <= bitcnt + 4'd1;
        if (bitcnt == 4'd7) begin
          addr_q <= cur_byte[6:0];
          dir_q  <= cur_byte[7];
          if (!cur_byte[7]) begin
            if (cur_byte[6:0] == BURST_ADR) begin
              burst <= 1'b1;
              bcap  <= 1'b1;
              bctr  <= '0;
            end else
              rd_pend <= 1'b1;
          end
        end
        if (bitcnt == 4'd15 && dir_q) begin
          reg_wdata     <= cur_byte;
          reg_wr        <= writable;
          reg_reset_req <= (addr_q == RST_ADR) && (cur_byte == RST_KEY);
        end
      end
      if (s_fall && (burst || (bitcnt[3] && !dir_q))) begin
        miso_q <= out_sr[OUTW-1];
        out_sr <= {out_sr[OUTW-2:0], 1'b0};
      end
    end

  p_no_wr_rd_clash_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));
  p_miso_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !s_fall |=> $stable(miso_o));
  p_cs_high_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s[1] |=> (!reg_wr && !reg_rd && !reg_reset_req));
  p_burst_addr_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && burst) |-> (reg_addr >= 7'h02 && reg_addr <= 7'h08));
  p_reset_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_reset_req |=> !reg_reset_req);
  p_wr_mapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> (reg_addr == 7'h02 || reg_addr == 7'h0B || reg_addr == 7'h11));
endmodule

// File: tb/spi_regport_bench.sv
`timescale 1ns/1ps
module spi_regport_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b1, mosi = 1'b0, cs_n = 1'b1;
  logic miso_o, miso_oe, reg_wr, reg_rd, reg_reset_req;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;

  int checks = 0, errors = 0;
  int wr_cnt = 0, rd_cnt = 0, rst_cnt = 0;
  logic [6:0] last_wa;
  logic [7:0] last_wd;
  logic [6:0] rd_log [0:15];
  logic [7:0] mem [0:127];
  bit done = 0;

  always #10 clk = ~clk;

  spi_regport u_spi_regport (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
    .miso_o(miso_o), .miso_oe(miso_oe), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_rdata(reg_rdata), .reg_reset_req(reg_reset_req));

  assign reg_rdata = mem[reg_addr];

  always @(posedge clk) begin
    if (reg_wr) begin
      wr_cnt++; last_wa = reg_addr; last_wd = reg_wdata; mem[reg_addr] = reg_wdata;
    end
    if (reg_rd) begin
      rd_log[rd_cnt[3:0]] = reg_addr; rd_cnt++;
    end
    if (reg_reset_req) rst_cnt++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [6:0] a);
    if (a == 7'h00) return 8'h0D;
    if (a == 7'h3F) return 8'hF2;
    if (a >= 7'h01 && a <= 7'h11) return mem[a];
    return 8'h00;
  endfunction

  function automatic bit fwd_wr(input logic [6:0] a);
    return a == 7'h02 || a == 7'h0B || a == 7'h11;
  endfunction

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      sclk = 1'b0; mosi = tx[i];
      #200;
      rx[i] = miso_o;
      sclk = 1'b1;
      #200;
    end
  endtask

  task automatic write_cmd(input logic [6:0] a, input logic [7:0] d);
    logic [7:0] junk;
    cs_n = 1'b0; #300;
    xbyte({1'b1, a}, junk);
    xbyte(d, junk);
    #300; cs_n = 1'b1; #400;
  endtask

  task automatic read_cmd(input logic [6:0] a, output logic [7:0] d);
    logic [7:0] junk;
    cs_n = 1'b0; #300;
    xbyte({1'b0, a}, junk);
    #1000;
    xbyte(8'h00, d);
    #300; cs_n = 1'b1; #400;
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, junk;
    int w0, r0, s0;
    void'($urandom(32'd4711));
    for (int i = 0; i < 128; i++) mem[i] = 8'($urandom);
    #7; #100; rst_n = 1'b1; #200;

    check("R3 reset oe", miso_oe, 0);
    check("R3 reset strobes", {reg_wr, reg_rd, reg_reset_req}, 0);

    r0 = rd_cnt;
    read_cmd(7'h00, d); check("R8 id", d, 8'h0D);
    read_cmd(7'h3F, d); check("R8 inverse id", d, 8'hF2);
    check("R8 no rd strobe", rd_cnt - r0, 0);

    r0 = rd_cnt;
    read_cmd(7'h05, d); check("R9 mapped read", d, mem[5]);
    check("R9 one strobe", rd_cnt - r0, 1);
    r0 = rd_cnt;
    read_cmd(7'h20, d); check("R9 unmapped read", d, 0);
    check("R9 unmapped no strobe", rd_cnt - r0, 0);

    w0 = wr_cnt;
    write_cmd(7'h11, 8'h3C);
    check("R1 write strobe", wr_cnt - w0, 1);
    check("R1 write addr", last_wa, 7'h11);
    check("R1 write data", last_wd, 8'h3C);
    read_cmd(7'h11, d); check("R2 readback", d, 8'h3C);

    w0 = wr_cnt;
    write_cmd(7'h05, 8'h77);
    write_cmd(7'h40, 8'h12);
    check("R10 dropped writes", wr_cnt - w0, 0);

    w0 = wr_cnt; s0 = rst_cnt;
    write_cmd(7'h3A, 8'h5B);
    check("R7 wrong key", rst_cnt - s0, 0);
    write_cmd(7'h3A, 8'h5A);
    check("R7 reset request", rst_cnt - s0, 1);
    check("R7 not forwarded", wr_cnt - w0, 0);

    // R4 abort mid-address, then a clean write
    w0 = wr_cnt;
    cs_n = 1'b0; #300;
    for (int i = 7; i >= 3; i--) begin
      sclk = 1'b0; mosi = (i == 7) ? 1'b1 : 1'b0; #200; sclk = 1'b1; #200;
    end
    cs_n = 1'b1; #400;
    check("R4 abort no strobe", wr_cnt - w0, 0);
    write_cmd(7'h0B, 8'hC3);
    check("R4 reframed count", wr_cnt - w0, 1);
    check("R4 reframed addr", last_wa, 7'h0B);

    // R11 back-to-back inside one select period
    w0 = wr_cnt;
    cs_n = 1'b0; #300;
    xbyte({1'b1, 7'h02}, junk); xbyte(8'hA5, junk);
    #500;
    xbyte({1'b0, 7'h02}, junk); #1000; xbyte(8'h00, d);
    #300; cs_n = 1'b1; #400;
    check("R11 second cmd write", wr_cnt - w0, 1);
    check("R11 second cmd read", d, 8'hA5);

    // R5/R6 burst
    begin
      logic [7:0] exp_b [0:6];
      for (int k = 0; k < 7; k++) exp_b[k] = mem[2 + k];
      r0 = rd_cnt; w0 = wr_cnt;
      cs_n = 1'b0; #300;
      xbyte({1'b0, 7'h42}, junk);
      #1000;
      for (int k = 0; k < 7; k++) begin
        xbyte(8'h00, d);
        check("R5 burst byte", d, exp_b[k]);
      end
      check("R5 burst strobes", rd_cnt - r0, 7);
      for (int k = 0; k < 7; k++)
        check("R5 burst order", rd_log[(r0 + k) % 16], 7'(2 + k));
      xbyte(8'h00, d);
      check("R6 beyond burst zero", d, 0);
      xbyte({1'b1, 7'h11}, junk); xbyte(8'h99, junk);
      #300; cs_n = 1'b1; #400;
      check("R6 locked no write", wr_cnt - w0, 0);
      check("R6 locked no read", rd_cnt - r0, 7);
      read_cmd(7'h00, d);
      check("R6 unlocked after select", d, 8'h0D);
    end

    // random mix
    for (int n = 0; n < 40; n++) begin
      logic [6:0] a;
      logic [7:0] v, e;
      a = 7'($urandom_range(0, 7'h41));
      if (a == 7'h3A) a = 7'h02;
      if ($urandom_range(0, 1) == 1) begin
        v = 8'($urandom);
        w0 = wr_cnt;
        write_cmd(a, v);
        if (fwd_wr(a)) check("R1 random write", last_wd, v);
        check("R10 random write count", wr_cnt - w0, fwd_wr(a) ? 1 : 0);
      end else begin
        e = exp_read(a);
        read_cmd(a, d);
        check("R9 random read", d, e);
      end
    end
    check("R3 idle oe", miso_oe, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule